// File: doc/BRIEF.md
# Auto-reload down-counter timer

This block is a 16-bit down-counting timer for a processor's register space. Software writes a 16-bit reload value one byte at a time into a low and a high holding byte. A load command copies the holding value into the live counter and restarts the prescaler. While the start control is high the counter steps down on every prescaler tick. The prescaler divides the clock by 16, or by 2 when the fast clock select is high.

When a tick finds the counter at zero, the block reloads the holding value, sets the time-out flag and raises the interrupt, so it runs periodically with a period of (holding value + 1) ticks. Software clears the flag and the interrupt by pulsing the write-one-to-clear input or by dropping the start control. Byte reads return the live count. Reading the low byte freezes the high byte of that same count, so a following high-byte read gives a coherent 16-bit value.

The run control is a small state machine with two states. **ST_STOP** moves to **ST_RUN** on the transition *start* (run input high). **ST_RUN** moves back to **ST_STOP** on the transition *halt* (run input low). Any other input keeps the current state. Counting happens only while the state is ST_RUN and the run input is still high.

Top module: `cdt_timer`

## Requirements
- R1: A write strobe on the low or high byte updates only the holding value. A low-byte read after such a write still shows the count from before the write.
- R2: While `rd_lo` is high, `rd_data` shows count bits 7:0. While `rd_hi` is high, `rd_data` shows count bits 15:8 as they were at the clock edge of the most recent `rd_lo`. With neither strobe high, `rd_data` is 0.
- R3: A `load_req` pulse sets `ld_pend` after the next edge. At the edge after that, the counter takes the holding value, the prescaler returns to zero and `ld_pend` clears, unless the request is repeated.
- R4: The counter holds its value while the run input is low, and for the first cycle after the run input rises, which is the ST_STOP to ST_RUN transition.
- R5: With `fast_sel` low, the counter steps once every 16 counting cycles.
- R6: With `fast_sel` high, the counter steps once every 2 counting cycles.
- R7: A tick that finds the count at 0 reloads the holding value and sets `to_flag` and `irq` after that edge.
- R8: `to_clr` high at an edge clears `to_flag` and `irq`. A low run input at an edge also clears them.
- R9: If a time-out and a clear fall on the same edge, the time-out wins and the flag ends up set.
- R10: After reset the count, holding value and read shadow are 0, and `to_flag`, `irq` and `ld_pend` are low. The state is ST_STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe, holding byte 7:0 |
| wr_hi | input | 1 | Write strobe, holding byte 15:8 |
| wr_data | input | 8 | Write data |
| rd_lo | input | 1 | Read strobe, live count 7:0; freezes high byte |
| rd_hi | input | 1 | Read strobe, frozen high byte |
| rd_data | output | 8 | Read data (combinational) |
| run | input | 1 | Start control, level |
| load_req | input | 1 | Load command pulse |
| fast_sel | input | 1 | Prescaler select: 0 gives divide by 16, 1 gives divide by 2 |
| to_clr | input | 1 | Write-one-to-clear for the time-out flag |
| ld_pend | output | 1 | Load command pending, self-clearing |
| to_flag | output | 1 | Time-out flag |
| irq | output | 1 | Timer interrupt |

## Verification
Read data is combinational, so it is due in the same cycle as the strobe. The frozen high byte, `ld_pend`, `to_flag` and `irq` are due one edge after their cause. A loaded count appears two edges after `load_req`. A reload on time-out appears one edge after the tick that found zero. The bench drives inputs just after the falling edge. It steps a behavioural model at each rising edge and compares every output at the next falling edge, so each result is read in exactly the cycle it is due. The same-edge clash between clear and time-out is set up from the model's prediction of the next tick.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

endpackage

// File: rtl/cdt_hold.sv
module cdt_hold #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  hold,
    output logic [BYTE_W-1:0] rd_data
);

    logic [LANES-1:0]  wr_en;
    logic [BYTE_W-1:0] shadow_q;

    assign wr_en = {wr_hi, wr_lo};

    // one holding byte per write lane
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[lane*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en[lane]) begin
                hold[lane*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    // high byte frozen on a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rd_lo) begin
            shadow_q <= cnt[CNT_W-1 -: BYTE_W];
        end
    end

    always_comb begin
        if (rd_lo) begin
            rd_data = cnt[BYTE_W-1:0];
        end else if (rd_hi) begin
            rd_data = shadow_q;
        end else begin
            rd_data = '0;
        end
    end

    assert_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo ##1 (rd_hi && !rd_lo)) |-> rd_data == $past(cnt[CNT_W-1 -: BYTE_W]));

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int SLOW_DIV = 16,
    parameter int FAST_DIV = 2,
    localparam int PRE_W  = $clog2(SLOW_DIV),
    localparam int FAST_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clr,
    input  logic fast,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;
    logic             slow_hit;
    logic             fast_hit;

    assign slow_hit = (pre_q == PRE_W'(SLOW_DIV - 1));
    assign fast_hit = (pre_q[FAST_W-1:0] == FAST_W'(FAST_DIV - 1));
    assign tick     = active && !clr && (fast ? fast_hit : slow_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (active) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assert_pre_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

    assert_pre_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_exec,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold,
    input  logic             run,
    input  logic             to_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             to_flag
);

    logic timeout;

    assign timeout = tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld_exec || timeout) begin
            cnt <= hold;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // a fresh time-out outranks any clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
        end else if (timeout) begin
            to_flag <= 1'b1;
        end else if (to_clr || !run) begin
            to_flag <= 1'b0;
        end
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_exec |=> cnt == $past(hold));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_exec) |=> $stable(cnt));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !ld_exec) |=> (to_flag && cnt == $past(hold)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((to_clr || !run) && !timeout) |=> !to_flag);

    assert_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && to_clr) |=> to_flag);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SLOW_DIV = 16,
    parameter int FAST_DIV = 2,
    localparam int LANES   = 2,
    localparam int CNT_W   = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              run,
    input  logic              load_req,
    input  logic              fast_sel,
    input  logic              to_clr,
    output logic              ld_pend,
    output logic              to_flag,
    output logic              irq
);

    run_st_e          st_q;
    run_st_e          st_d;
    logic             active;
    logic             tick;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: start / halt
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: if (run)  st_d = ST_RUN;
            ST_RUN:  if (!run) st_d = ST_STOP;
            default: st_d = ST_STOP;
        endcase
    end

    // state-dependent outputs
    always_comb begin
        active = 1'b0;
        unique case (st_q)
            ST_STOP: active = 1'b0;
            ST_RUN:  active = run;
            default: active = 1'b0;
        endcase
    end

    // self-clearing load bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend <= 1'b0;
        end else begin
            ld_pend <= load_req;
        end
    end

    cdt_hold #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .cnt     (cnt),
        .hold    (hold),
        .rd_data (rd_data)
    );

    cdt_prescale #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .clr    (ld_pend),
        .fast   (fast_sel),
        .tick   (tick)
    );

    cdt_count #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_exec (ld_pend),
        .tick    (tick),
        .hold    (hold),
        .run     (run),
        .to_clr  (to_clr),
        .cnt     (cnt),
        .to_flag (to_flag)
    );

    assign irq = to_flag;

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP) |-> !tick);

    assert_ldclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pend && !load_req) |=> !ld_pend);

endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 0, wr_hi = 0, rd_lo = 0, rd_hi = 0;
    logic [7:0] wr_data = '0;
    logic       run = 0, load_req = 0, fast_sel = 0, to_clr = 0;
    logic [7:0] rd_data;
    logic       ld_pend, to_flag, irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_tag = "R10";

    // behavioural model state
    int m_hold = 0, m_cnt = 0, m_pre = 0, m_sh = 0;
    bit m_ldp = 0, m_st = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .run(run),
        .load_req(load_req), .fast_sel(fast_sel), .to_clr(to_clr),
        .ld_pend(ld_pend), .to_flag(to_flag), .irq(irq)
    );

    function automatic bit m_tick_next();
        bit hit;
        hit = fast_sel ? (m_pre % 2 == 1) : (m_pre == 15);
        return m_st && run && !m_ldp && hit;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_cnt = 0; m_pre = 0; m_sh = 0;
            m_ldp = 0; m_st = 0; m_flag = 0;
        end else begin
            int  h_old;
            bit  tk;
            bit  tmo;
            h_old = m_hold;
            tk  = m_tick_next();
            tmo = 0;
            if (wr_lo) m_hold = (m_hold & 32'hFF00) | wr_data;
            if (wr_hi) m_hold = (m_hold & 32'h00FF) | (int'(wr_data) << 8);
            if (rd_lo) m_sh = (m_cnt >> 8) & 8'hFF;
            if (m_ldp) begin
                m_cnt = h_old; m_pre = 0;
            end else if (m_st && run) begin
                m_pre = (m_pre + 1) % 16;
                if (tk) begin
                    if (m_cnt == 0) begin m_cnt = h_old; tmo = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            m_ldp = load_req;
            if (tmo) m_flag = 1;
            else if (to_clr || !run) m_flag = 0;
            m_st = run;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd;
            exp_rd = rd_lo ? (m_cnt & 8'hFF) : (rd_hi ? m_sh : 0);
            check({cur_tag, "/R2 rd_data"}, rd_data, exp_rd);
            check({cur_tag, "/R7 to_flag"}, to_flag, m_flag);
            check({cur_tag, "/R8 irq"}, irq, m_flag);
            check({cur_tag, "/R3 ld_pend"}, ld_pend, m_ldp);
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr_lo = 0; wr_hi = 0; load_req = 0; to_clr = 0;
            rd_lo = (i % 5 == 0); rd_hi = (i % 5 == 2);
        end
    endtask

    task automatic set_hold(input int v);
        @(negedge clk); #1;
        rd_lo = 0; rd_hi = 0;
        wr_lo = 1; wr_hi = 1; wr_data = v[7:0];
        @(negedge clk); #1;
        wr_lo = 0; wr_data = v[15:8];
        @(negedge clk); #1;
        wr_hi = 0;
    endtask

    task automatic do_load();
        @(negedge clk); #1;
        load_req = 1;
        cyc(3);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        cyc(4);
        @(negedge clk); #1 rst_n = 1;
        // R10: reset state
        cur_tag = "R10";
        @(negedge clk); #1 rd_lo = 1;
        #1 check("R10 count low", rd_data, 0);
        check("R10 to_flag", to_flag, 0);
        check("R10 ld_pend", ld_pend, 0);

        // R1: holding write leaves the count alone
        cur_tag = "R1";
        set_hold(16'h0003);
        @(negedge clk); #1 rd_lo = 1; rd_hi = 0;
        #1 check("R1 count after write", rd_data, 0);

        // R3: load path
        cur_tag = "R3";
        @(negedge clk); #1 rd_lo = 0; load_req = 1;
        @(negedge clk); #1 load_req = 0;
        check("R3 ld_pend set", ld_pend, 1);
        @(negedge clk); #1 rd_lo = 1;
        #1 check("R3 loaded count", rd_data, 3);
        check("R3 ld_pend cleared", ld_pend, 0);

        // R4: stopped count holds
        cur_tag = "R4";
        cyc(20);
        @(negedge clk); #1 rd_lo = 1;
        #1 check("R4 stopped count", rd_data, 3);

        // R6 + R7: fast run through time-outs
        cur_tag = "R6";
        @(negedge clk); #1 fast_sel = 1; run = 1;
        cyc(12);
        cur_tag = "R7";
        cyc(10);
        check("R7 flag after wrap", to_flag, 1);

        // R8: write-one-to-clear
        cur_tag = "R8";
        for (int k = 0; k < 40 && m_tick_next(); k++) cyc(1);
        @(negedge clk); #1 to_clr = 1;
        cyc(1);

        // R5: slow prescaler
        cur_tag = "R5";
        set_hold(16'h0102);
        do_load();
        @(negedge clk); #1 fast_sel = 0;
        cyc(80);

        // R8: halt clears flag
        cur_tag = "R8";
        set_hold(16'h0001);
        @(negedge clk); #1 fast_sel = 1; load_req = 1;
        cyc(12);
        @(negedge clk); #1 run = 0;
        cyc(1);
        check("R8 halt clears", to_flag, 0);
        cyc(6);

        // R9: clear on the time-out edge
        cur_tag = "R9";
        @(negedge clk); #1 run = 1;
        begin
            bit hit = 0;
            for (int k = 0; k < 60 && !hit; k++) begin
                @(negedge clk); #1;
                rd_lo = 0; rd_hi = 0; to_clr = 0;
                if (m_tick_next() && m_cnt == 0) begin
                    to_clr = 1; hit = 1;
                end
            end
            @(negedge clk); #1 to_clr = 0;
            check("R9 time-out wins", to_flag, 1);
        end

        // R2: coherent split read
        cur_tag = "R2";
        set_hold(16'h0345);
        do_load();
        cyc(9);
        @(negedge clk); #1 rd_lo = 1; rd_hi = 0;
        @(negedge clk); #1 rd_lo = 0;
        cyc(0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1 rd_lo = 0; rd_hi = 1;
        end
        @(negedge clk); #1 rd_hi = 0; run = 0;
        cyc(4);
        finish_run();
    end

endmodule